// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that completes one instruction in every clock. Each cycle it fetches a word from a small internal instruction store, decodes it, and reads two source registers. The ALU then operates, the data store may be accessed, and the result is written back. The program counter, the register file and the data store change only at the rising clock edge, and only when the decoder enables that write. Everything between those state elements is combinational.

Decoding takes two levels. A main decoder turns the 6-bit opcode into one fixed set of mux selects and write enables, along with a 2-bit operation class. A second decoder combines that class with the 6-bit function field and produces the 4-bit ALU command. A load port fills either internal store before the program starts. The port outputs show the architectural effect of each cycle: the current PC, the fetched word, the register write and the store. A test environment can follow execution without reaching into the core.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and all 32 registers become 0. While `rst` is high, no register or data-store write takes place and `wb_en_o` and `st_en_o` are low.
- R2: Opcode 0 is register-type. Instruction bits [25:21] select the first source, [20:16] the second source and [15:11] the destination. Function code bits [5:0] select the operation: 100000 add, 100010 subtract, 100100 AND, 100101 OR.
- R3: The ALU command comes from a 2-bit class and the function field. Class 00 is used by loads and stores and makes the ALU add. Class 01 is used by branch-if-equal and makes it subtract. Class 10 is used by register-type instructions and defers to the function code. The ALU commands are 0010 add, 0110 subtract, 0000 AND, 0001 OR, 0111 set-on-less-than and 1100 NOR.
- R4: Function code 101010 writes 1 to the destination when the first source is less than the second as signed 32-bit values, and 0 otherwise.
- R5: Opcode 35 is a word load. Bits [15:0] are a signed offset. The byte address is the first source (bits [25:21]) plus the sign-extended offset. Address bits [1:0] are ignored and the word index wraps to the data-store size. The loaded word is written to the register in bits [20:16].
- R6: Opcode 43 is a word store. It uses the same address as a load and writes the register in bits [20:16] to the data store. `st_en_o` goes high with `st_addr_o` showing the byte address and `st_data_o` the data. No register is written.
- R7: Opcode 4 is branch-if-equal. When the two sources are equal, the next PC is PC+4 plus the sign-extended offset shifted left by 2. Otherwise the next PC is PC+4. Nothing is written.
- R8: Opcode 2 is a jump. The next PC is bits [31:28] of PC+4 followed by instruction bits [25:0] and then two zero bits. Nothing is written.
- R9: Register 0 always reads as 0. A write aimed at it is discarded and `wb_en_o` stays low.
- R10: Any other opcode writes nothing and the next PC is PC+4.
- R11: When `ld_en` is high at a rising edge, `ld_data` is written to word `ld_addr`. It goes to the instruction store when `ld_sel_data` is 0 and to the data store when it is 1.
- R12: The fetched word `instr_o` is the instruction-store word indexed by PC bits [log2(IMEM_WORDS)+1:2]. The upper PC bits take no part in the fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Load-port write strobe |
| ld_sel_data | input | 1 | Load-port target: 0 instruction store, 1 data store |
| ld_addr | input | LD_AW | Load-port word index |
| ld_data | input | 32 | Load-port word |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction fetched this cycle |
| wb_en_o | output | 1 | A register is written at the next edge |
| wb_addr_o | output | 5 | Register being written |
| wb_data_o | output | 32 | Value being written |
| st_en_o | output | 1 | The data store is written at the next edge |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Word being stored |

## Verification
Within a single cycle an instruction may read a register that the same instruction overwrites at the closing edge. Examples are a load whose base register is also its target, or an add whose destination equals one of its sources. A branch may also compare a register against itself. Generated programs draw register numbers mostly from a small set so that these overlaps happen often. An architectural model in the bench, built from the requirements, predicts each cycle's PC, write and store. The core's outputs are compared with that model in mid-cycle, so a wrong read-before-write order shows up at once as a mismatch on the next cycle's value.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OPC_REG   = 6'd0;
    localparam logic [5:0] OPC_LOAD  = 6'd35;
    localparam logic [5:0] OPC_STORE = 6'd43;
    localparam logic [5:0] OPC_BEQ   = 6'd4;
    localparam logic [5:0] OPC_JUMP  = 6'd2;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111,
        ALU_NOR = 4'b1100
    } alu_cmd_e;

    typedef enum logic [1:0] {
        CLS_ADDR  = 2'b00,
        CLS_CMP   = 2'b01,
        CLS_FUNCT = 2'b10
    } op_class_e;

    typedef struct packed {
        logic      dst_rd;
        logic      src_imm;
        logic      wb_from_mem;
        logic      reg_we;
        logic      mem_rd;
        logic      mem_we;
        logic      is_branch;
        logic      is_jump;
        op_class_e cls;
    } ctrl_t;

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '0;
        ctrl.cls = CLS_ADDR;
        case (opcode)
            OPC_REG: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_we = 1'b1;
                ctrl.cls    = CLS_FUNCT;
            end
            OPC_LOAD: begin
                ctrl.src_imm     = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_we      = 1'b1;
                ctrl.mem_rd      = 1'b1;
            end
            OPC_STORE: begin
                ctrl.src_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.cls       = CLS_CMP;
            end
            OPC_JUMP: begin
                ctrl.is_jump = 1'b1;
            end
            default: begin
                ctrl = '0;
            end
        endcase
    end

endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
    import sc_core_pkg::*;
(
    input  op_class_e  cls,
    input  logic [5:0] funct,
    output alu_cmd_e   cmd
);

    always_comb begin
        cmd = ALU_ADD;
        case (cls)
            CLS_ADDR: cmd = ALU_ADD;
            CLS_CMP:  cmd = ALU_SUB;
            CLS_FUNCT: begin
                case (funct)
                    FN_ADD:  cmd = ALU_ADD;
                    FN_SUB:  cmd = ALU_SUB;
                    FN_AND:  cmd = ALU_AND;
                    FN_OR:   cmd = ALU_OR;
                    FN_SLT:  cmd = ALU_SLT;
                    default: cmd = ALU_ADD;
                endcase
            end
            default: cmd = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_cmd_e     cmd,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        case (cmd)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_NOR: y = ~(a | b);
            default: y = a + b;
        endcase
        zero = (y == '0);
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);

    logic [W-1:0] regs_d [NREG];
    logic [W-1:0] regs_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            if (rst) begin
                regs_d[i] = '0;
            end else if (we && (waddr != '0) && (waddr == AW'(i))) begin
                regs_d[i] = wdata;
            end else begin
                regs_d[i] = regs_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            regs_q[i] <= regs_d[i];
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];

    // R2: an enabled write to a nonzero register is visible one edge later
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (we && waddr != '0) |=> regs_q[$past(waddr)] == $past(wdata));

    // R9: register 0 never holds anything but zero once reset has run
    p_zero_reg_r9: assert property (@(posedge clk) disable iff (rst)
        $past(we) |-> regs_q[0] == '0);

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter int IMEM_WORDS = 256,
    parameter int DMEM_WORDS = 64,
    localparam int LD_AW = $clog2((IMEM_WORDS > DMEM_WORDS) ? IMEM_WORDS : DMEM_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic             ld_sel_data,
    input  logic [LD_AW-1:0] ld_addr,
    input  logic [31:0]      ld_data,
    output logic [31:0]      pc_o,
    output logic [31:0]      instr_o,
    output logic             wb_en_o,
    output logic [4:0]       wb_addr_o,
    output logic [31:0]      wb_data_o,
    output logic             st_en_o,
    output logic [31:0]      st_addr_o,
    output logic [31:0]      st_data_o
);

    localparam int IAW  = $clog2(IMEM_WORDS);
    localparam int DAW  = $clog2(DMEM_WORDS);
    localparam int NREG = 32;
    localparam int RAW  = $clog2(NREG);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t st_d, st_q;

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] instr;
    logic [5:0]      f_op;
    logic [RAW-1:0]  f_rs, f_rt, f_rd;
    logic [5:0]      f_fn;
    logic [15:0]     f_imm;
    logic [25:0]     f_tgt;

    ctrl_t           ctrl;
    alu_cmd_e        alu_cmd;
    logic [XLEN-1:0] rs_data, rt_data, imm_ext, alu_b, alu_y;
    logic            alu_zero;
    logic [XLEN-1:0] load_word, wb_value;
    logic [RAW-1:0]  wb_dest;
    logic            rf_we, store_en;
    logic [XLEN-1:0] pc_seq, pc_br, pc_jmp;

    // fetch and field split
    assign instr = imem[st_q.pc[IAW+1:2]];
    assign f_op  = instr[31:26];
    assign f_rs  = instr[25:21];
    assign f_rt  = instr[20:16];
    assign f_rd  = instr[15:11];
    assign f_fn  = instr[5:0];
    assign f_imm = instr[15:0];
    assign f_tgt = instr[25:0];

    sc_main_dec u_main_dec (
        .opcode (f_op),
        .ctrl   (ctrl)
    );

    sc_alu_dec u_alu_dec (
        .cls   (ctrl.cls),
        .funct (f_fn),
        .cmd   (alu_cmd)
    );

    sc_regfile #(.NREG(NREG), .W(XLEN)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (wb_dest),
        .wdata (wb_value),
        .ra1   (f_rs),
        .ra2   (f_rt),
        .rd1   (rs_data),
        .rd2   (rt_data)
    );

    assign imm_ext = {{(XLEN-16){f_imm[15]}}, f_imm};
    assign alu_b   = ctrl.src_imm ? imm_ext : rt_data;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rs_data),
        .b    (alu_b),
        .cmd  (alu_cmd),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign load_word = ctrl.mem_rd ? dmem[alu_y[DAW+1:2]] : '0;
    assign wb_value  = ctrl.wb_from_mem ? load_word : alu_y;
    assign wb_dest   = ctrl.dst_rd ? f_rd : f_rt;
    assign rf_we     = ctrl.reg_we & ~rst;
    assign store_en  = ctrl.mem_we & ~rst;

    // next-state computation
    always_comb begin
        pc_seq = st_q.pc + 32'd4;
        pc_br  = pc_seq + {imm_ext[XLEN-3:0], 2'b00};
        pc_jmp = {pc_seq[31:28], f_tgt, 2'b00};
        st_d   = st_q;
        if (rst) begin
            st_d.pc = '0;
        end else if (ctrl.is_jump) begin
            st_d.pc = pc_jmp;
        end else if (ctrl.is_branch && alu_zero) begin
            st_d.pc = pc_br;
        end else begin
            st_d.pc = pc_seq;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // stores written by the load port
    always_ff @(posedge clk) begin
        if (ld_en && !ld_sel_data) begin
            imem[ld_addr[IAW-1:0]] <= ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (ld_en && ld_sel_data) begin
            dmem[ld_addr[DAW-1:0]] <= ld_data;
        end else if (store_en) begin
            dmem[alu_y[DAW+1:2]] <= rt_data;
        end
    end

    assign pc_o      = st_q.pc;
    assign instr_o   = instr;
    assign wb_en_o   = rf_we && (wb_dest != '0);
    assign wb_addr_o = wb_dest;
    assign wb_data_o = wb_value;
    assign st_en_o   = store_en;
    assign st_addr_o = alu_y;
    assign st_data_o = rt_data;

    // R10: anything that is neither branch nor jump steps the PC by one word
    p_seq_pc_r10: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.is_jump && !ctrl.is_branch) |=> st_q.pc == $past(st_q.pc) + 32'd4);

    // R7: equal operands on a branch redirect to the offset target
    p_br_taken_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.is_branch && rs_data == rt_data) |=>
        st_q.pc == $past(st_q.pc) + 32'd4 +
                   {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

    // R7: unequal operands fall through
    p_br_fall_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.is_branch && rs_data != rt_data) |=> st_q.pc == $past(st_q.pc) + 32'd4);

    // R8: jump keeps the region bits of PC+4 and takes the word target
    p_jump_r8: assert property (@(posedge clk) disable iff (rst)
        ctrl.is_jump |=>
        st_q.pc == ((($past(st_q.pc) + 32'd4) & 32'hF000_0000) |
                    {4'b0000, $past(instr[25:0]), 2'b00}));

    // R6: a store never writes a register in the same cycle
    p_store_no_wb_r6: assert property (@(posedge clk) disable iff (rst)
        st_en_o |-> !wb_en_o);

    // R5: memory address is base plus sign-extended offset
    p_mem_addr_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mem_we || ctrl.mem_rd) |-> alu_y == rs_data + {{16{instr[15]}}, instr[15:0]});

endmodule

// File: tb/sc_core_test.sv
module sc_core_test;

    localparam int IW    = 256;
    localparam int DW    = 64;
    localparam int IAW   = 8;
    localparam int DAW   = 6;
    localparam int LAW   = 8;
    localparam int NPROG = 16;
    localparam int STEPS = 400;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           ld_en = 1'b0;
    logic           ld_sel_data = 1'b0;
    logic [LAW-1:0] ld_addr = '0;
    logic [31:0]    ld_data = '0;
    logic [31:0]    pc_o, instr_o, wb_data_o, st_addr_o, st_data_o;
    logic           wb_en_o, st_en_o;
    logic [4:0]     wb_addr_o;

    sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) uut (
        .clk         (clk),
        .rst         (rst),
        .ld_en       (ld_en),
        .ld_sel_data (ld_sel_data),
        .ld_addr     (ld_addr),
        .ld_data     (ld_data),
        .pc_o        (pc_o),
        .instr_o     (instr_o),
        .wb_en_o     (wb_en_o),
        .wb_addr_o   (wb_addr_o),
        .wb_data_o   (wb_data_o),
        .st_en_o     (st_en_o),
        .st_addr_o   (st_addr_o),
        .st_data_o   (st_data_o)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_imem [IW];
    logic [31:0] m_dmem [DW];
    logic [31:0] m_reg  [32];
    logic [31:0] m_pc;
    logic [31:0] seed = 32'h1234_5678;

    function automatic logic [31:0] nxt();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
        return {6'd0, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic build_program(int prog);
        logic [31:0] r, r2;
        logic [4:0]  rs, rt, rd;
        logic [5:0]  fns [5];
        fns[0] = 6'b100000; fns[1] = 6'b100010; fns[2] = 6'b100100;
        fns[3] = 6'b100101; fns[4] = 6'b101010;
        for (int i = 0; i < DW; i++) begin
            case (i)
                0: m_dmem[i] = 32'h0000_0000;
                1: m_dmem[i] = 32'h0000_0001;
                2: m_dmem[i] = 32'hFFFF_FFFF;
                3: m_dmem[i] = 32'h7FFF_FFFF;
                4: m_dmem[i] = 32'h8000_0000;
                5: m_dmem[i] = 32'h0000_0001;
                6: m_dmem[i] = 32'hFFFF_FFFE;
                default: m_dmem[i] = nxt();
            endcase
        end
        for (int i = 0; i < IW; i++) begin
            r  = nxt();
            r2 = nxt();
            rs = r[27] ? r[20:16] : {2'b00, r[2:0]};
            rt = {2'b00, r[5:3]};
            rd = r[26] ? r[14:10] : {2'b00, r[8:6]};
            case (r[31:28])
                4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6:
                    m_imem[i] = enc_r(rs, rt, rd, fns[r2[7:0] % 5]);
                4'd7, 4'd8, 4'd9:
                    m_imem[i] = enc_i(6'd35, r2[9] ? rs : 5'd0, rt,
                                      r2[0] ? {8'h00, r2[8:1]} : r2[31:16]);
                4'd10, 4'd11:
                    m_imem[i] = enc_i(6'd43, r2[9] ? rs : 5'd0, rt,
                                      r2[0] ? {8'h00, r2[8:1]} : r2[31:16]);
                4'd12, 4'd13:
                    m_imem[i] = enc_i(6'd4, rs, r2[4] ? rs : rt, {{12{r2[19]}}, r2[19:16]});
                4'd14:
                    m_imem[i] = {6'd2, r2[5] ? r2[25:0] : {18'd0, r2[17:10]}};
                default:
                    m_imem[i] = {r2[6] ? 6'd63 : 6'd8, r[25:0]};
            endcase
        end
        if (prog == 0) begin
            m_imem[0]  = enc_i(6'd35, 5'd0, 5'd1, 16'd8);       // r1 = -1
            m_imem[1]  = enc_i(6'd35, 5'd0, 5'd2, 16'd4);       // r2 = 1
            m_imem[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'b101010);    // slt -> 1
            m_imem[3]  = enc_r(5'd2, 5'd1, 5'd4, 6'b101010);    // slt -> 0
            m_imem[4]  = enc_r(5'd2, 5'd1, 5'd5, 6'b100010);    // 1-(-1)=2
            m_imem[5]  = enc_r(5'd1, 5'd2, 5'd0, 6'b100000);    // write to r0
            m_imem[6]  = enc_i(6'd43, 5'd2, 5'd5, 16'h0100);    // store at 0x101
            m_imem[7]  = enc_i(6'd35, 5'd2, 5'd6, 16'hFFFC);    // addr wraps
            m_imem[8]  = enc_i(6'd4, 5'd1, 5'd1, 16'd2);        // taken to 44
            m_imem[9]  = 32'hFC00_0000;
            m_imem[10] = 32'hFC00_0000;
            m_imem[11] = enc_i(6'd4, 5'd1, 5'd2, 16'hFFFB);     // not taken
            m_imem[12] = 32'hFC00_0000;                          // unknown opcode
            m_imem[13] = {6'd2, 26'h20};                        // jump to 0x80
            m_imem[32] = {6'd2, 26'h0};
        end
    endtask

    task automatic preload();
        for (int i = 0; i < IW; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_sel_data = 1'b0; ld_addr = LAW'(i); ld_data = m_imem[i];
        end
        for (int i = 0; i < DW; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_sel_data = 1'b1; ld_addr = LAW'(i); ld_data = m_dmem[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic step_and_check(int prog, int step);
        logic [31:0] ins, a, b, sx, adr, res, npc;
        logic [5:0]  op, fn;
        logic [4:0]  rs, rt, rd;
        logic        e_wb, e_st;
        logic [4:0]  e_wa;
        logic [31:0] e_wd;
        string       tag;
        ins = m_imem[m_pc[IAW+1:2]];
        op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; fn = ins[5:0];
        a  = m_reg[rs]; b = m_reg[rt];
        sx = {{16{ins[15]}}, ins[15:0]};
        adr = a + sx;
        npc = m_pc + 32'd4;
        e_wb = 1'b0; e_st = 1'b0; e_wa = 5'd0; e_wd = 32'd0;
        tag = "R10";
        case (op)
            6'd0: begin
                tag = "R2 R3";
                case (fn)
                    6'b100000: res = a + b;
                    6'b100010: res = a - b;
                    6'b100100: res = a & b;
                    6'b100101: res = a | b;
                    default: begin res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R4"; end
                endcase
                e_wa = rd; e_wd = res; e_wb = (rd != 5'd0);
            end
            6'd35: begin
                tag = "R5 R3";
                e_wa = rt; e_wd = m_dmem[adr[DAW+1:2]]; e_wb = (rt != 5'd0);
            end
            6'd43: begin
                tag = "R6"; e_st = 1'b1;
            end
            6'd4: begin
                tag = "R7 R3";
                if (a == b) npc = m_pc + 32'd4 + {sx[29:0], 2'b00};
            end
            6'd2: begin
                tag = "R8";
                npc = {npc[31:28], ins[25:0], 2'b00};
            end
            default: tag = "R10";
        endcase
        if (!e_wb && (op == 6'd0 || op == 6'd35)) tag = "R9";
        check("R11 R12", instr_o, ins, "instr");
        check(tag, pc_o, m_pc, "pc");
        check(tag, {31'd0, wb_en_o}, {31'd0, e_wb}, "wb_en");
        if (e_wb) begin
            check(tag, {27'd0, wb_addr_o}, {27'd0, e_wa}, "wb_addr");
            check(tag, wb_data_o, e_wd, "wb_data");
        end
        check(tag, {31'd0, st_en_o}, {31'd0, e_st}, "st_en");
        if (e_st) begin
            check(tag, st_addr_o, adr, "st_addr");
            check(tag, st_data_o, b, "st_data");
        end
        if (prog == 0 && step == 2) check("R4", wb_data_o, 32'd1, "signed less-than");
        if (prog == 0 && step == 3) check("R4", wb_data_o, 32'd0, "signed not-less");
        if (prog == 0 && step == 6) check("R6", st_addr_o, 32'h0000_0101, "store address");
        if (prog == 0 && step == 9) check("R7", pc_o, 32'd44, "branch target");
        if (prog == 0 && step == 12) check("R8", pc_o, 32'h0000_0080, "jump target");
        if (e_wb) m_reg[e_wa] = e_wd;
        if (e_st) m_dmem[adr[DAW+1:2]] = b;
        m_pc = npc;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int p = 0; p < NPROG; p++) begin
            rst = 1'b1;
            build_program(p);
            preload();
            #1;
            // R1: reset state observed while reset is still held
            check("R1", pc_o, 32'd0, "reset pc");
            check("R1", {31'd0, wb_en_o}, 32'd0, "reset wb_en");
            check("R1", {31'd0, st_en_o}, 32'd0, "reset st_en");
            for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
            m_pc = 32'd0;
            rst = 1'b0;
            #1;
            for (int s = 0; s < STEPS; s++) begin
                step_and_check(p, s);
                @(negedge clk);
                #1;
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule